// File: doc/BRIEF.md
# Ternary Lookup Table Built from Parity-Protected Match Banks

This block performs ternary (value plus don't-care) lookups over a small rule table without a true ternary cell array. The search key is cut into equal chunks. Each chunk indexes its own bank of plain single-bit-per-rule storage. Every bank word is a vector holding one bit per rule. A set bit means that rule accepts that chunk value. The final per-rule match is the AND of the vectors read from all banks. A priority encoder then reports the lowest-numbered matching rule.

Every bank word carries one even-parity bit, so soft errors in the storage are caught during normal lookups rather than by a separate scan. When any bank returns a word whose bits do not XOR to zero, the block reports the lowest-numbered failing bank and the key chunk that addressed it. An external corrector uses these two values to rebuild the word. A write port loads or repairs one word per cycle. That port runs in parallel with lookups, as in a simple dual-port memory. Lookups have one cycle of latency, and every result field, error reporting included, appears in the same cycle.

Top module: `sram_tcam`

## Requirements
- R1: While rst_ni is low, every output is zero. Reset clears every bank word to zero, so a lookup made after reset matches no rule and flags no error.
- R2: Bank b is addressed by key bits [b*CHUNK_W +: CHUNK_W]. Bit e (e < NUM_ENTRIES) of the word read is rule e's acceptance of that chunk value, and bit NUM_ENTRIES is the parity bit.
- R3: One cycle after lookup_valid_i is high, match_vec_o equals the bitwise AND of the rule bits read from all banks, taken whether or not parity fails. In a cycle that follows no lookup, match_vec_o is zero.
- R4: hit_o is high exactly when match_vec_o is nonzero. hit_idx_o is then the lowest set index of match_vec_o, and is zero when there is no hit.
- R5: Parity is even. A bank flags an error when the XOR of all NUM_ENTRIES+1 bits of its word read is 1. err_valid_o is high one cycle after a lookup in which at least one bank flagged, and an even number of flipped bits goes unflagged.
- R6: With err_valid_o high, err_bank_o is the lowest-numbered flagging bank and err_chunk_o is the key chunk that addressed that bank. Both are zero when err_valid_o is low.
- R7: err_multi_o is high when two or more banks flag in the same lookup, and is otherwise low.
- R8: With wr_en_i high, wr_data_i is written to word wr_addr_i of bank wr_bank_i. Lookups issued from the next cycle onward see the new word, while a lookup in the same cycle at the same address still reads the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_valid_i | input | 1 | Start a lookup with lookup_key_i |
| lookup_key_i | input | NUM_BANKS*CHUNK_W | Search key |
| wr_en_i | input | 1 | Write one bank word |
| wr_bank_i | input | clog2(NUM_BANKS) | Bank selected for write |
| wr_addr_i | input | CHUNK_W | Word address within the bank |
| wr_data_i | input | NUM_ENTRIES+1 | Word to write: parity at top, rule bits below |
| match_vec_o | output | NUM_ENTRIES | Per-rule match result |
| hit_o | output | 1 | At least one rule matched |
| hit_idx_o | output | clog2(NUM_ENTRIES) | Lowest matching rule |
| err_valid_o | output | 1 | Parity failure seen in this lookup |
| err_bank_o | output | clog2(NUM_BANKS) | Lowest failing bank |
| err_chunk_o | output | CHUNK_W | Key chunk that addressed the failing bank |
| err_multi_o | output | 1 | More than one bank failed |

## Verification
A corrupted or misaddressed bank word is visible at the ports on the first lookup whose key chunk selects that word, one cycle after the lookup is issued. It shows as a wrong match vector, a wrong hit index, or a parity flag naming the wrong bank or chunk. The bench keeps its own copy of every bank word, updated only from the write port, and compares every output field on every cycle. A write that lands at the wrong address or in the wrong cycle therefore shows up on the next lookup that touches either word. Faults are injected deliberately, with single, double and parity-only flips in one or two banks, and they are also written in the same cycle as a lookup of the same word. This exercises the order of the error encoder and the read-before-write behaviour.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tcam_bank.sv
module tcam_bank #(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              par_err_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rd_q;

  // read and write in the same cycle: read returns the pre-write word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
      if (rd_en_i) rd_q <= mem_q[rd_addr_i];
    end
  end

  assign rd_word_o = rd_q;
  assign par_err_o = ^rd_q;
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = int'(WIDTH) - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/tcam_err_enc.sv
module tcam_err_enc #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ID_W      = 2,
  parameter int unsigned CHUNK_W   = 4
) (
  input  logic [NUM_BANKS-1:0]         err_i,
  input  logic [NUM_BANKS*CHUNK_W-1:0] chunks_i,
  output logic                         any_o,
  output logic                         multi_o,
  output logic [ID_W-1:0]              id_o,
  output logic [CHUNK_W-1:0]           chunk_o
);
  always_comb begin
    id_o    = '0;
    chunk_o = '0;
    for (int i = int'(NUM_BANKS) - 1; i >= 0; i--) begin
      if (err_i[i]) begin
        id_o    = ID_W'(i);
        chunk_o = chunks_i[i*CHUNK_W +: CHUNK_W];
      end
    end
  end
  assign any_o   = |err_i;
  assign multi_o = $countones(err_i) > 1;
endmodule

// File: rtl/sram_tcam.sv
module sram_tcam #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned CHUNK_W     = 4,
  parameter int unsigned NUM_BANKS   = 4,
  localparam int unsigned KEY_W  = NUM_BANKS * CHUNK_W,
  localparam int unsigned WORD_W = NUM_ENTRIES + 1,
  localparam int unsigned BANK_W = tcam_pkg::idx_width(NUM_BANKS),
  localparam int unsigned IDX_W  = tcam_pkg::idx_width(NUM_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_valid_i,
  input  logic [KEY_W-1:0]   lookup_key_i,
  input  logic               wr_en_i,
  input  logic [BANK_W-1:0]  wr_bank_i,
  input  logic [CHUNK_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic [NUM_ENTRIES-1:0] match_vec_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               err_valid_o,
  output logic [BANK_W-1:0]  err_bank_o,
  output logic [CHUNK_W-1:0] err_chunk_o,
  output logic               err_multi_o
);
  logic [WORD_W-1:0]    rd_word [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_err;
  logic                 valid_q;
  logic [KEY_W-1:0]     key_q;

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en_i && (wr_bank_i == BANK_W'(b));
    tcam_bank #(.WORD_W(WORD_W), .ADDR_W(CHUNK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_we),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (lookup_valid_i),
      .rd_addr_i (lookup_key_i[b*CHUNK_W +: CHUNK_W]),
      .rd_word_o (rd_word[b]),
      .par_err_o (bank_err[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      key_q   <= '0;
    end else begin
      valid_q <= lookup_valid_i;
      if (lookup_valid_i) key_q <= lookup_key_i;
    end
  end

  logic [NUM_ENTRIES-1:0] match_all;
  always_comb begin
    match_all = '1;
    for (int b = 0; b < int'(NUM_BANKS); b++) match_all &= rd_word[b][NUM_ENTRIES-1:0];
  end

  logic             found;
  logic [IDX_W-1:0] idx;
  tcam_prio_enc #(.WIDTH(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .vec_i   (match_all),
    .found_o (found),
    .idx_o   (idx)
  );

  logic               err_any, err_multi;
  logic [BANK_W-1:0]  err_id;
  logic [CHUNK_W-1:0] err_chunk;
  tcam_err_enc #(.NUM_BANKS(NUM_BANKS), .ID_W(BANK_W), .CHUNK_W(CHUNK_W)) u_err (
    .err_i    (bank_err),
    .chunks_i (key_q),
    .any_o    (err_any),
    .multi_o  (err_multi),
    .id_o     (err_id),
    .chunk_o  (err_chunk)
  );

  logic err_v;
  assign err_v       = valid_q && err_any;
  assign match_vec_o = valid_q ? match_all : '0;
  assign hit_o       = valid_q && found;
  assign hit_idx_o   = valid_q ? idx : '0;
  assign err_valid_o = err_v;
  assign err_bank_o  = err_v ? err_id : '0;
  assign err_chunk_o = err_v ? err_chunk : '0;
  assign err_multi_o = err_v && err_multi;
endmodule

// File: rtl/tcam_chk.sv
module tcam_chk #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned CHUNK_W     = 4,
  parameter int unsigned NUM_BANKS   = 4,
  localparam int unsigned KEY_W  = NUM_BANKS * CHUNK_W,
  localparam int unsigned BANK_W = tcam_pkg::idx_width(NUM_BANKS),
  localparam int unsigned IDX_W  = tcam_pkg::idx_width(NUM_ENTRIES)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lookup_valid_i,
  input logic [KEY_W-1:0]       lookup_key_i,
  input logic [NUM_ENTRIES-1:0] match_vec_o,
  input logic                   hit_o,
  input logic [IDX_W-1:0]       hit_idx_o,
  input logic                   err_valid_o,
  input logic [BANK_W-1:0]      err_bank_o,
  input logic [CHUNK_W-1:0]     err_chunk_o,
  input logic                   err_multi_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (match_vec_o == '0 && !hit_o && !err_valid_o && !err_multi_o);
    end
  end

  // R3
  idle_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lookup_valid_i) |-> (match_vec_o == '0 && !hit_o));

  // R4
  hit_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_vec_o[hit_idx_o] &&
      ((match_vec_o & ((NUM_ENTRIES'(1) << hit_idx_o) - NUM_ENTRIES'(1))) == '0)));

  // R4
  miss_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (match_vec_o == '0 && hit_idx_o == '0));

  // R5
  err_after_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> $past(lookup_valid_i));

  // R6
  err_chunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (err_chunk_o ==
      CHUNK_W'($past(lookup_key_i) >> (int'(err_bank_o) * int'(CHUNK_W)))));

  // R7
  multi_implies_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_multi_o |-> err_valid_o);
endmodule

bind sram_tcam tcam_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .CHUNK_W     (CHUNK_W),
  .NUM_BANKS   (NUM_BANKS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_key_i   (lookup_key_i),
  .match_vec_o    (match_vec_o),
  .hit_o          (hit_o),
  .hit_idx_o      (hit_idx_o),
  .err_valid_o    (err_valid_o),
  .err_bank_o     (err_bank_o),
  .err_chunk_o    (err_chunk_o),
  .err_multi_o    (err_multi_o)
);

// File: tb/sram_tcam_tb.sv
module sram_tcam_tb;
  localparam int NE = 8, CW = 4, NB = 4, KW = NB * CW, WW = NE + 1, DEPTH = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lk_v = 0;
  logic [KW-1:0] lk_key = '0;
  logic          we = 0;
  logic [1:0]    wb = '0;
  logic [CW-1:0] wa = '0;
  logic [WW-1:0] wd = '0;

  logic [NE-1:0] match_vec;
  logic          hit, err_v, err_m;
  logic [2:0]    hit_idx;
  logic [1:0]    err_b;
  logic [CW-1:0] err_c;

  sram_tcam u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lk_v), .lookup_key_i(lk_key),
    .wr_en_i(we), .wr_bank_i(wb), .wr_addr_i(wa), .wr_data_i(wd),
    .match_vec_o(match_vec), .hit_o(hit), .hit_idx_o(hit_idx),
    .err_valid_o(err_v), .err_bank_o(err_b), .err_chunk_o(err_c), .err_multi_o(err_m)
  );

  // reference state
  logic [WW-1:0] mdl [NB][DEPTH];
  logic [KW-1:0] t_val [NE];
  logic [KW-1:0] t_care [NE];
  logic [NE-1:0] x_match;
  logic          x_hit, x_ev, x_multi;
  int            x_idx, x_bank;
  logic [CW-1:0] x_chunk;
  int vectors = 0, miscompares = 0;
  string scen = "R1 reset";
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin : model
    logic [NE-1:0] m;
    int nerr;
    logic [WW-1:0] w;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) for (int a = 0; a < DEPTH; a++) mdl[b][a] = '0;
      x_match = '0; x_hit = 0; x_idx = 0; x_ev = 0; x_bank = 0; x_chunk = '0; x_multi = 0;
    end else begin
      x_match = '0; x_hit = 0; x_idx = 0; x_ev = 0; x_bank = 0; x_chunk = '0; x_multi = 0;
      if (lk_v) begin
        m = '1; nerr = 0;
        for (int b = NB - 1; b >= 0; b--) begin
          w = mdl[b][lk_key[b*CW +: CW]];
          m &= w[NE-1:0];
          if (^w) begin
            nerr++; x_ev = 1; x_bank = b; x_chunk = lk_key[b*CW +: CW];
          end
        end
        x_multi = nerr > 1;
        x_match = m;
        x_hit = |m;
        for (int i = NE - 1; i >= 0; i--) if (m[i]) x_idx = i;
      end
      if (we) mdl[wb][wa] = wd;
    end
  end

  task automatic field(input string tag, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        field("R1 outputs in reset", {match_vec, hit, hit_idx, err_v, err_b, err_c, err_m}, 0);
      end else begin
        field("R2 R3 match_vec", match_vec, x_match);
        field("R4 hit", hit, x_hit);
        field("R4 hit_idx", hit_idx, x_idx);
        field("R5 err_valid", err_v, x_ev);
        field("R6 err_bank", err_b, x_bank);
        field("R6 err_chunk", err_c, x_chunk);
        field("R7 err_multi", err_m, x_multi);
      end
    end
  end

  task automatic cyc(input logic v, input logic [KW-1:0] k, input logic w,
                     input int b, input int a, input logic [WW-1:0] d);
    @(negedge clk);
    lk_v = v; lk_key = k; we = w; wb = 2'(b); wa = CW'(a); wd = d;
  endtask

  task automatic look(input logic [KW-1:0] k);
    cyc(1, k, 0, 0, 0, '0);
  endtask

  function automatic logic [WW-1:0] good_word(input int b, input int a);
    logic [NE-1:0] bits;
    for (int e = 0; e < NE; e++)
      bits[e] = ((CW'(a) ^ t_val[e][b*CW +: CW]) & t_care[e][b*CW +: CW]) == '0;
    return {^bits, bits};
  endfunction

  task automatic load_table();
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < DEPTH; a++) cyc(0, '0, 1, b, a, good_word(b, a));
    cyc(0, '0, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    scen = "R1 lookup after reset";
    look(16'h1234); look(16'h0000); cyc(0, '0, 0, 0, 0, '0);

    scen = "R2 R8 table load";
    t_val[0] = 16'h1234; t_care[0] = 16'hFFFF;
    t_val[1] = 16'h1200; t_care[1] = 16'hFF00;
    t_val[2] = 16'h0000; t_care[2] = 16'h0000;
    t_val[3] = 16'hABCD; t_care[3] = 16'hFFFF;
    t_val[4] = 16'h1234; t_care[4] = 16'hFFFF;
    t_val[5] = 16'h0F0F; t_care[5] = 16'hF0F0;
    t_val[6] = 16'h8000; t_care[6] = 16'h8000;
    t_val[7] = 16'hFFFF; t_care[7] = 16'hFFFF;
    load_table();

    scen = "R3 R4 lookups";
    look(16'h1234); look(16'h12FF); look(16'hABCD); look(16'hFFFF); look(16'h0505);
    cyc(0, 16'h1234, 0, 0, 0, '0);
    look(16'h1234);

    scen = "R4 no wildcard";
    t_val[2] = 16'h5555; t_care[2] = 16'hFFFF;
    load_table();
    look(16'h7777); look(16'h9999); look(16'hFFFF); look(16'h5555);

    scen = "R5 R6 single flip bank1";
    cyc(0, '0, 1, 1, 3, mdl[1][3] ^ 9'h001);
    look(16'h1234); look(16'h1244);

    scen = "R7 second bank parity flip";
    cyc(0, '0, 1, 3, 1, mdl[3][1] ^ 9'h100);
    look(16'h1234); look(16'h1200);

    scen = "R5 double flip unseen";
    cyc(0, '0, 1, 0, 4, mdl[0][4] ^ 9'h003);
    look(16'h1234); look(16'hABC4);

    scen = "R8 repair";
    cyc(0, '0, 1, 1, 3, good_word(1, 3));
    cyc(0, '0, 1, 3, 1, good_word(3, 1));
    cyc(0, '0, 1, 0, 4, good_word(0, 4));
    look(16'h1234);

    scen = "R8 write same cycle as lookup";
    cyc(1, 16'h1234, 1, 2, 2, good_word(2, 2) ^ 9'h004);
    look(16'h1234);
    cyc(1, 16'h1234, 1, 2, 2, good_word(2, 2));
    look(16'h1234);

    scen = "R3 R5 R6 R7 mixed traffic";
    for (int n = 0; n < 400; n++) begin
      int e, b, a;
      logic [KW-1:0] k;
      e = $urandom_range(0, NE - 1);
      k = t_val[e] ^ (KW'($urandom) & ~t_care[e]);
      if ($urandom_range(0, 3) == 0) k = KW'($urandom);
      b = $urandom_range(0, NB - 1);
      a = $urandom_range(0, DEPTH - 1);
      case ($urandom_range(0, 7))
        0: cyc($urandom_range(0, 1) == 1, k, 1, b, a, good_word(b, a) ^ (WW'(1) << $urandom_range(0, WW - 1)));
        1: cyc($urandom_range(0, 1) == 1, k, 1, b, a, good_word(b, a));
        default: cyc($urandom_range(0, 3) != 0, k, 0, 0, 0, '0);
      endcase
    end
    cyc(0, '0, 0, 0, 0, '0);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule